// File: doc/BRIEF.md
# Timing-Error Rollback Register Queue

This block is a register queue for a modulo-scheduled loop datapath that runs with timing-error detection. Data for several lanes enters at the head, and the queue shifts by one entry on every clock cycle that is not stalled. The head entry is sampled twice. A main flop samples on the clock edge. A shadow flop samples on a late strobe, after the input has settled. On a valid capture, a difference between the two marks that lane as failed. The lane error flags are OR-reduced into a registered error, which then passes through a synchronizer chain before the recovery controller acts on it.

The queue holds extra backup entries beyond its nominal depth. When a stabilized error reaches the controller, the controller raises a stall and shifts the queue backwards one entry per cycle through the rollback multiplexers. This runs for as many cycles as the detection latency. On the last step it writes the settled shadow value into the head entry. When the stall drops, the taps are as they would have been if the failing capture had been correct. The producer then re-issues every iteration after the failing one. A saturating counter records each recovery so that a frequency/voltage governor can track the error rate.

Top module: `trq_queue`

## Requirements
- R1: On every clock edge where stall_o was low, tap 0 takes data_i and valid_i, and each tap k takes the old contents of tap k-1. Tap k occupies taps_o bits [k*LANES*W +: LANES*W], and lane l of a tap occupies bits [l*W +: W] of that slice.
- R2: A lane error is raised only when the entry captured on the previous edge is valid and its main sample differs from the shadow sample taken on shadow_strobe_i. A mismatch on an entry captured with valid_i low never causes a stall.
- R3: After a failing capture edge, stall_o stays low for the next OR_LAT+SYNC_STAGES edges and is high after the edge that follows them. OR_LAT is one cycle.
- R4: Once high, stall_o stays high for exactly OR_LAT+SYNC_STAGES cycles, then drops. The backup depth EXTRA = OR_LAT+SYNC_STAGES+PIPE_DEPTH is never smaller than this rollback length.
- R5: data_i and valid_i have no effect while stall_o is high.
- R6: When stall_o drops, the taps equal the queue contents just after the failing capture, with the shadow value in tap 0. Iterations captured after the failing one are discarded.
- R7: Errors on captures made after a failing capture and before its recovery starts do not cause a further recovery.
- R8: err_count_o increases by one at the start of each recovery, saturates at 2^CNT_W-1, and changes at no other time.
- R9: During reset all tap valid bits are 0, stall_o is 0 and err_count_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | LANES*W | Iteration data, all lanes |
| valid_i | input | 1 | The iteration on data_i is real (not a bubble) |
| shadow_strobe_i | input | 1 | Late sampling strobe for the shadow flops |
| taps_o | output | DEPTH*LANES*W | Nominal queue entries, tap 0 newest |
| tap_valid_o | output | DEPTH | Valid bit of each tap |
| stall_o | output | 1 | Recovery in progress; upstream must hold and later replay |
| err_count_o | output | CNT_W | Saturating count of recoveries |

## Verification
A stream of iterations with interleaved bubbles is driven. Selected iterations get a wrong value before the clock edge and the settled value before the strobe. Errors are injected on a single lane in low and high bits, on both lanes, and on two back-to-back iterations. These cases separate a per-lane compare from a broken OR-reduction, and the back-to-back case tells a single recovery apart from a duplicate one. An error injected on the second iteration after reset checks that the rollback pulls invalid backup entries into the taps. Bubbles always carry a mismatch, which shows whether the valid gating works. Ten recoveries against a 3-bit counter exercise saturation.

// File: rtl/trq_pkg.sv
package trq_pkg;
  typedef enum logic {
    CTL_IDLE,
    CTL_ROLL
  } ctl_state_e;
endpackage

// File: rtl/trq_lane_sample.sv
module trq_lane_sample #(
  parameter int W = 8
) (
  input  logic         strobe_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] main_i,
  output logic [W-1:0] shadow_o,
  output logic         mismatch_o
);
  // late sample of the same input the main flop saw at the clock edge
  always_ff @(posedge strobe_i or negedge rst_ni) begin
    if (!rst_ni) shadow_o <= '0;
    else         shadow_o <= d_i;
  end

  assign mismatch_o = (main_i != shadow_o);
endmodule

// File: rtl/trq_err_tree.sv
module trq_err_tree #(
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_err_i,
  input  logic             qualify_i,
  input  logic             block_i,
  input  logic             flush_i,
  output logic             err_stable_o,
  output logic             new_err_o
);
  logic                   any_err;
  logic                   or_q;
  logic                   inflight;
  logic [SYNC_STAGES-1:0] sync_q;

  assign any_err   = |lane_err_i;
  assign inflight  = or_q | (|sync_q);
  // first error of a window; later ones get rolled back with it
  assign new_err_o = any_err & qualify_i & ~block_i & ~inflight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) or_q <= 1'b0;
    else         or_q <= any_err & qualify_i & ~block_i;
  end

  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sync_q <= '0;
      else if (flush_i) sync_q <= '0;
      else              sync_q <= or_q;
    end
  end else begin : g_syncn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sync_q <= '0;
      else if (flush_i) sync_q <= '0;
      else              sync_q <= {sync_q[SYNC_STAGES-2:0], or_q};
    end
  end

  assign err_stable_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/trq_roll_ctrl.sv
module trq_roll_ctrl
  import trq_pkg::*;
#(
  parameter int ROLL  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_stable_i,
  output logic             stall_o,
  output logic             last_o,
  output logic             flush_o,
  output logic [CNT_W-1:0] err_count_o
);
  localparam int CW = $clog2(ROLL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctl_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign stall_o = err_stable_i | (state_q == CTL_ROLL);
  assign flush_o = err_stable_i & (state_q == CTL_IDLE);
  assign last_o  = (state_q == CTL_ROLL) && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CTL_IDLE;
      cnt_q       <= '0;
      err_count_o <= '0;
    end else begin
      case (state_q)
        CTL_IDLE: if (err_stable_i) begin
          state_q <= CTL_ROLL;
          cnt_q   <= CW'(ROLL - 1);
          if (err_count_o != CNT_MAX) err_count_o <= err_count_o + 1'b1;
        end
        default: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= CTL_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/trq_queue.sv
module trq_queue #(
  parameter int LANES       = 2,
  parameter int W           = 8,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_DEPTH  = 1,
  parameter int CNT_W       = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [LANES*W-1:0]       data_i,
  input  logic                     valid_i,
  input  logic                     shadow_strobe_i,
  output logic [DEPTH*LANES*W-1:0] taps_o,
  output logic [DEPTH-1:0]         tap_valid_o,
  output logic                     stall_o,
  output logic [CNT_W-1:0]         err_count_o
);
  localparam int LW     = LANES * W;
  localparam int OR_LAT = 1;
  localparam int ROLL   = OR_LAT + SYNC_STAGES;
  localparam int EXTRA  = ROLL + PIPE_DEPTH;
  localparam int N      = DEPTH + EXTRA;

  logic [LW-1:0]    q_d [N];
  logic [N-1:0]     q_v;
  logic [LW-1:0]    shadow_vec;
  logic [LANES-1:0] lane_err;
  logic [LW-1:0]    corr_q;
  logic             cap_q;
  logic             err_stable, new_err, flush, last;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    trq_lane_sample #(.W(W)) u_smp (
      .strobe_i   (shadow_strobe_i),
      .rst_ni     (rst_ni),
      .d_i        (data_i[l*W +: W]),
      .main_i     (q_d[0][l*W +: W]),
      .shadow_o   (shadow_vec[l*W +: W]),
      .mismatch_o (lane_err[l])
    );
  end

  trq_err_tree #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) u_tree (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lane_err_i   (lane_err),
    .qualify_i    (cap_q & q_v[0]),
    .block_i      (stall_o),
    .flush_i      (flush),
    .err_stable_o (err_stable),
    .new_err_o    (new_err)
  );

  trq_roll_ctrl #(.ROLL(ROLL), .CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .err_stable_i (err_stable),
    .stall_o      (stall_o),
    .last_o       (last),
    .flush_o      (flush),
    .err_count_o  (err_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      corr_q <= '0;
    end else begin
      cap_q <= ~stall_o;
      if (new_err) corr_q <= shadow_vec;
    end
  end

  // forward shift when running, one-step backward shift per stalled cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) q_d[k] <= '0;
      q_v <= '0;
    end else if (stall_o) begin
      for (int k = 0; k < N-1; k++) begin
        q_d[k]   <= q_d[k+1];
        q_v[k]   <= q_v[k+1];
      end
      q_d[N-1] <= '0;
      q_v[N-1] <= 1'b0;
      if (last) q_d[0] <= corr_q;
    end else begin
      q_d[0] <= data_i;
      q_v[0] <= valid_i;
      for (int k = 1; k < N; k++) begin
        q_d[k] <= q_d[k-1];
        q_v[k] <= q_v[k-1];
      end
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    assign taps_o[k*LW +: LW] = q_d[k];
    assign tap_valid_o[k]     = q_v[k];
  end
endmodule

// File: rtl/trq_queue_chk.sv
module trq_queue_chk #(
  parameter int LANES       = 2,
  parameter int W           = 8,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_DEPTH  = 1,
  parameter int CNT_W       = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [LANES*W-1:0]       data_i,
  input logic                     valid_i,
  input logic [DEPTH*LANES*W-1:0] taps_o,
  input logic [DEPTH-1:0]         tap_valid_o,
  input logic                     stall_o,
  input logic [CNT_W-1:0]         err_count_o
);
  localparam int LW    = LANES * W;
  localparam int ROLL  = 1 + SYNC_STAGES;
  localparam int EXTRA = ROLL + PIPE_DEPTH;
  localparam int RW    = $clog2(EXTRA + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (stall_o) run_q <= run_q + 1'b1;
    else              run_q <= '0;
  end

  assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> (tap_valid_o[0] == $past(valid_i)) && (taps_o[LW-1:0] == $past(data_i)));

  assert_stall_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (run_q < RW'(ROLL)) && (run_q < RW'(EXTRA)));

  assert_stall_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_o) |-> (run_q == RW'(ROLL)));

  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(stall_o) |=> $stable(err_count_o));

  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |=> (err_count_o == (($past(err_count_o) == CNT_MAX) ?
                                        CNT_MAX : $past(err_count_o) + 1'b1)));
endmodule

bind trq_queue trq_queue_chk #(
  .LANES(LANES), .W(W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES),
  .PIPE_DEPTH(PIPE_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_i      (data_i),
  .valid_i     (valid_i),
  .taps_o      (taps_o),
  .tap_valid_o (tap_valid_o),
  .stall_o     (stall_o),
  .err_count_o (err_count_o)
);

// File: tb/trq_queue_tb_top.sv
`timescale 1ns/1ps
module trq_queue_tb_top;
  localparam int LANES = 2, W = 8, DEPTH = 4, SYNC = 2, PIPE = 1, CNT_W = 3;
  localparam int LW = LANES * W;
  localparam int L = 1 + SYNC;
  localparam int CMAX = 7;
  localparam int NSLOT = 90;

  logic clk = 1'b0, rst_ni = 1'b0, strobe = 1'b0, valid_i = 1'b0;
  logic [LW-1:0]       data_i = '0;
  logic [DEPTH*LW-1:0] taps_o;
  logic [DEPTH-1:0]    tap_valid_o;
  logic                stall_o;
  logic [CNT_W-1:0]    err_count_o;

  trq_queue #(.LANES(LANES), .W(W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC),
              .PIPE_DEPTH(PIPE), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .shadow_strobe_i(strobe), .taps_o(taps_o), .tap_valid_o(tap_valid_o),
    .stall_o(stall_o), .err_count_o(err_count_o));

  always #4 clk = ~clk;
  always begin
    @(posedge clk);
    #2 strobe = 1'b1;
    #1 strobe = 1'b0;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [LW-1:0] slot_val(int n);
    return {8'(n * 11 + 200), 8'(n * 37 + 5)};
  endfunction
  function automatic bit is_bubble(int n);
    return (n % 7) == 5;
  endfunction
  function automatic logic [LW-1:0] slot_mask(int n);
    case (n)
      1:                  return 16'h0001;
      6:                  return 16'h0080;
      15:                 return 16'h0100;
      24:                 return 16'hFFFF;
      36, 37:             return 16'h0010;
      41, 49, 57, 65, 73: return 16'h0204;
      default:            return 16'h0000;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [LW-1:0] exp_d [DEPTH];
  logic [LW-1:0] snap_d [DEPTH];
  bit            exp_v [DEPTH];
  bit            snap_v [DEPTH];
  bit            used [NSLOT];

  task automatic check_taps(string req, bit use_snap);
    bit ok;
    logic [63:0] ev;
    ok = 1'b1;
    ev = '0;
    for (int k = 0; k < DEPTH; k++) begin
      bit v;
      logic [LW-1:0] d;
      v = use_snap ? snap_v[k] : exp_v[k];
      d = use_snap ? snap_d[k] : exp_d[k];
      if (tap_valid_o[k] != v) ok = 1'b0;
      if (v && taps_o[k*LW +: LW] != d) ok = 1'b0;
      if (v) ev[k*LW +: LW] = d;
    end
    check(ok, req, "taps", taps_o & {{LW{tap_valid_o[3]}}, {LW{tap_valid_o[2]}},
                                    {LW{tap_valid_o[1]}}, {LW{tap_valid_o[0]}}}, ev);
  endtask

  initial begin
    int n, age, err_n, rec;
    bit inflight, bub, junk_seen;
    logic [LW-1:0] good, mask;
    n = 0; age = 0; err_n = 0; rec = 0; inflight = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin exp_d[k] = '0; exp_v[k] = 1'b0; end
    repeat (3) @(negedge clk);
    check(tap_valid_o == '0, "R9", "reset tap valid", 64'(tap_valid_o), 0);
    check(stall_o == 1'b0, "R9", "reset stall", 64'(stall_o), 0);
    check(err_count_o == '0, "R9", "reset count", 64'(err_count_o), 0);
    rst_ni = 1'b1;
    while (n < NSLOT) begin
      @(negedge clk);
      if (inflight) begin
        age++;
        if (age <= L)
          check(stall_o == 1'b0, "R3", "stall before detection", 64'(stall_o), 0);
        else if (age <= 2 * L)
          check(stall_o == 1'b1, "R4", "stall during rollback", 64'(stall_o), 1);
        else begin
          check(stall_o == 1'b0, "R4", "stall release", 64'(stall_o), 0);
          check_taps("R6", 1'b1);
          junk_seen = 1'b0;
          for (int k = 0; k < DEPTH; k++)
            if (tap_valid_o[k] && taps_o[k*LW +: LW] == 16'hA5A5) junk_seen = 1'b1;
          check(!junk_seen, "R5", "stalled input leaked", 64'(junk_seen), 0);
          rec++;
          check(err_count_o == CNT_W'(rec < CMAX ? rec : CMAX), "R7", "recovery count",
                64'(err_count_o), 64'(rec < CMAX ? rec : CMAX));
          for (int k = 0; k < DEPTH; k++) begin exp_d[k] = snap_d[k]; exp_v[k] = snap_v[k]; end
          n = err_n + 1;
          inflight = 1'b0;
        end
      end else begin
        check(stall_o == 1'b0, "R2", "spurious stall", 64'(stall_o), 0);
        check_taps("R1", 1'b0);
      end

      if (stall_o) begin
        data_i  = 16'hA5A5;
        valid_i = 1'b1;
      end else begin
        good = slot_val(n);
        bub  = is_bubble(n);
        mask = used[n] ? '0 : slot_mask(n);
        valid_i = !bub;
        data_i  = bub ? ~good : (good ^ mask);
        for (int k = DEPTH - 1; k > 0; k--) begin
          exp_d[k] = exp_d[k-1];
          exp_v[k] = exp_v[k-1];
        end
        exp_d[0] = good;
        exp_v[0] = !bub;
        if (mask != '0 && !bub) begin
          used[n] = 1'b1;
          if (!inflight) begin
            inflight = 1'b1;
            age = 0;
            err_n = n;
            for (int k = 0; k < DEPTH; k++) begin snap_d[k] = exp_d[k]; snap_v[k] = exp_v[k]; end
          end
        end
        n++;
        @(posedge clk);
        #1 data_i = good;
      end
    end
    check(rec == 10, "R7", "recoveries seen", 64'(rec), 10);
    check(err_count_o == CNT_W'(CMAX), "R8", "saturated count", 64'(err_count_o), CMAX);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule